// File: doc/BRIEF.md
# Multichannel ADC Scan Sequencer

This block drives an external monitoring converter across up to eight measurement channels. Software uses a small register port to set a run mode, a start bit, a range select bit and an eight-bit channel enable mask. Once started, the sequencer visits the enabled channels in ascending index order. For each one it pulses a request carrying the channel index, waits for the converter's done pulse, and stores the returned sample in that channel's result register. A channel that does not answer within its time budget is abandoned and keeps its old result.

In one-shot mode a single pass runs and the start bit then clears itself. In continuous mode a pass begins once per repeat period, which is measured from the start of the previous pass. A low-power input keeps the converter idle: it blocks the start bit and aborts any pass in progress. Channel 0 is the battery voltage and channel 7 is the comparator input. The range select bit goes to the converter only with requests for channels 5 and 7. All time limits are counted in ticks of a prescaler whose division is a parameter.

Top module: `adc_scan_seq`

## Requirements
- R1: After reset the control word (address 0: bit 0 mode, bit 1 start, bit 2 range select) reads 3'b100. The mask (address 1, bits 7:0) reads 0. Every result register (address 8+channel) reads 0. No request is issued.
- R2: During a pass, each enabled channel is requested exactly once, in ascending index order. Disabled channels are skipped. Each request is a single-cycle `conv_req` pulse with the index on `conv_ch`.
- R3: A `conv_done` pulse while a channel is awaited stores `conv_result` in that channel's result register. No other result register changes.
- R4: With mode 0, writing start 1 runs exactly one pass. The start bit then reads 0, and no further requests follow.
- R5: During a request for channel 5 or 7, `conv_fullscale` equals the range select bit. For every other channel it is 0.
- R6: If no done pulse arrives within CH_TIMEOUT_TICKS ticks, the channel's previous result is kept and the next enabled channel is requested.
- R7: With mode 1, passes begin every PERIOD_TICKS ticks, within one tick of jitter. The start bit stays 1.
- R8: Clearing mode during continuous operation lets the current pass finish. Then the sequencer stops and the start bit reads 0.
- R9: While `low_power` is high, the start bit reads 0 and a write of start 1 has no effect, even after `low_power` falls.
- R10: Raising `low_power` during a pass stops all further requests and clears the start bit.
- R11: Starting with an all-zero mask issues no request and clears the start bit in one-shot mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| low_power | input | 1 | Low-power mode; forces the sequencer idle |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data (combinational from address) |
| conv_req | output | 1 | Single-cycle conversion request |
| conv_ch | output | CH_W | Channel index of the request |
| conv_fullscale | output | 1 | Range select sent with the request |
| conv_done | input | 1 | Converter done pulse |
| conv_result | input | RES_W | Converter sample, valid with done |

## Verification
The bench targets several corner cases. Each is listed with what a wrong design would show.

- Non-adjacent enable masks: a wrong priority encoder would request channels out of order or revisit one.
- A converter that never answers one channel: a wrong timeout would hang, or would overwrite that channel's old result.
- An empty mask, and a start write under low power: a wrong design would leave start stuck at 1 or issue a stray request.
- Low power raised in mid-pass, and mode cleared in mid-pass: a wrong design would keep requesting, or would cut the pass short instead of finishing it.
- The continuous repeat period: a wrong design would restart too early or too late.

// File: rtl/scan_pkg.sv
package scan_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PICK = 2'd1,
    ST_WAIT = 2'd2,
    ST_HOLD = 2'd3
  } scan_state_t;

  localparam int unsigned CTL_MODE  = 0;
  localparam int unsigned CTL_START = 1;
  localparam int unsigned CTL_RANGE = 2;
  localparam int unsigned ADDR_CTL  = 0;
  localparam int unsigned ADDR_MASK = 1;
endpackage

// File: rtl/scan_tick_gen.sv
module scan_tick_gen #(
  parameter int unsigned DIV = 100000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt_q, cnt_nx;

  always_comb begin
    tick   = (cnt_q == CW'(DIV - 1));
    cnt_nx = tick ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_nx;
  end
endmodule

// File: rtl/scan_results.sv
module scan_results #(
  parameter int unsigned N_CH  = 8,
  parameter int unsigned RES_W = 16,
  localparam int unsigned CH_W = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [CH_W-1:0]       wr_ch,
  input  logic [RES_W-1:0]      wr_data,
  output logic [N_CH*RES_W-1:0] res_flat
);
  genvar g;
  for (g = 0; g < N_CH; g++) begin : g_res
    logic [RES_W-1:0] val_q;
    logic             hit;
    assign hit = wr_en && (wr_ch == CH_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   val_q <= '0;
      else if (hit) val_q <= wr_data;
    end
    assign res_flat[g*RES_W +: RES_W] = val_q;
  end
endmodule

// File: rtl/scan_regs.sv
module scan_regs
  import scan_pkg::*;
#(
  parameter int unsigned N_CH   = 8,
  parameter int unsigned RES_W  = 16,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  low_power,
  input  logic                  reg_we,
  input  logic [ADDR_W-1:0]     reg_addr,
  input  logic [DATA_W-1:0]     reg_wdata,
  output logic [DATA_W-1:0]     reg_rdata,
  input  logic                  start_clr,
  input  logic [N_CH*RES_W-1:0] res_flat,
  output logic                  mode_bit,
  output logic                  start_bit,
  output logic                  range_bit,
  output logic [N_CH-1:0]       mask
);
  localparam int unsigned RES_BASE = 2 ** (ADDR_W - 1);

  logic            ctl_wr, mask_wr;
  logic            mode_nx, start_nx, range_nx;
  logic [N_CH-1:0] mask_nx;
  logic            unused_wdata;

  assign ctl_wr       = reg_we && (reg_addr == ADDR_W'(ADDR_CTL));
  assign mask_wr      = reg_we && (reg_addr == ADDR_W'(ADDR_MASK));
  assign unused_wdata = ^reg_wdata;

  always_comb begin
    mode_nx  = mode_bit;
    range_nx = range_bit;
    mask_nx  = mask;
    start_nx = start_bit;
    if (start_clr) start_nx = 1'b0;
    if (ctl_wr) begin
      mode_nx  = reg_wdata[CTL_MODE];
      range_nx = reg_wdata[CTL_RANGE];
      start_nx = reg_wdata[CTL_START];
    end
    if (mask_wr) mask_nx = reg_wdata[N_CH-1:0];
    if (low_power) start_nx = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_bit  <= 1'b0;
      start_bit <= 1'b0;
      range_bit <= 1'b1;
      mask      <= '0;
    end else begin
      mode_bit  <= mode_nx;
      start_bit <= start_nx;
      range_bit <= range_nx;
      mask      <= mask_nx;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_W'(ADDR_CTL)) begin
      reg_rdata[CTL_MODE]  = mode_bit;
      reg_rdata[CTL_START] = start_bit;
      reg_rdata[CTL_RANGE] = range_bit;
    end else if (reg_addr == ADDR_W'(ADDR_MASK)) begin
      reg_rdata[N_CH-1:0] = mask;
    end else begin
      for (int i = 0; i < N_CH; i++) begin
        if (reg_addr == ADDR_W'(RES_BASE + i))
          reg_rdata[RES_W-1:0] = res_flat[i*RES_W +: RES_W];
      end
    end
  end
endmodule

// File: rtl/scan_fsm.sv
module scan_fsm
  import scan_pkg::*;
#(
  parameter int unsigned N_CH             = 8,
  parameter int unsigned CH_TIMEOUT_TICKS = 25,
  parameter int unsigned PERIOD_TICKS     = 1000,
  localparam int unsigned CH_W = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            low_power,
  input  logic            start_bit,
  input  logic            mode_bit,
  input  logic [N_CH-1:0] mask,
  input  logic            conv_done,
  output logic            conv_req,
  output logic [CH_W-1:0] conv_ch,
  output logic            start_clr,
  output logic            res_we
);
  localparam int unsigned TOW = $clog2(CH_TIMEOUT_TICKS + 1);
  localparam int unsigned PW  = $clog2(PERIOD_TICKS + 1);

  scan_state_t     state_q, state_nx;
  logic [N_CH-1:0] pend_q, pend_nx;
  logic [CH_W-1:0] ch_q, ch_nx;
  logic            req_q, req_nx;
  logic [TOW-1:0]  to_q, to_nx;
  logic [PW-1:0]   per_q, per_nx;
  logic            pick_any;
  logic [CH_W-1:0] pick_idx;

  always_comb begin
    pick_any = |pend_q;
    pick_idx = '0;
    for (int i = N_CH - 1; i >= 0; i--) begin
      if (pend_q[i]) pick_idx = CH_W'(i);
    end
  end

  always_comb begin
    state_nx  = state_q;
    pend_nx   = pend_q;
    ch_nx     = ch_q;
    req_nx    = 1'b0;
    to_nx     = to_q;
    per_nx    = per_q;
    start_clr = 1'b0;
    res_we    = 1'b0;
    if (tick && (per_q != PW'(PERIOD_TICKS))) per_nx = per_q + 1'b1;

    case (state_q)
      ST_IDLE: begin
        if (start_bit && !low_power) begin
          pend_nx  = mask;
          per_nx   = '0;
          state_nx = ST_PICK;
        end
      end
      ST_PICK: begin
        if (pick_any) begin
          ch_nx            = pick_idx;
          pend_nx[pick_idx] = 1'b0;
          req_nx           = 1'b1;
          to_nx            = '0;
          state_nx         = ST_WAIT;
        end else if (mode_bit) begin
          state_nx = ST_HOLD;
        end else begin
          start_clr = 1'b1;
          state_nx  = ST_IDLE;
        end
      end
      ST_WAIT: begin
        if (conv_done) begin
          res_we   = 1'b1;
          state_nx = ST_PICK;
        end else if (tick) begin
          if (to_q == TOW'(CH_TIMEOUT_TICKS - 1)) state_nx = ST_PICK;
          else                                   to_nx    = to_q + 1'b1;
        end
      end
      ST_HOLD: begin
        if (!mode_bit || !start_bit) begin
          start_clr = 1'b1;
          state_nx  = ST_IDLE;
        end else if (per_q >= PW'(PERIOD_TICKS)) begin
          pend_nx  = mask;
          per_nx   = '0;
          state_nx = ST_PICK;
        end
      end
      default: state_nx = ST_IDLE;
    endcase

    if (low_power && (state_q != ST_IDLE)) begin
      state_nx  = ST_IDLE;
      req_nx    = 1'b0;
      res_we    = 1'b0;
      start_clr = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pend_q  <= '0;
      ch_q    <= '0;
      req_q   <= 1'b0;
      to_q    <= '0;
      per_q   <= '0;
    end else begin
      state_q <= state_nx;
      pend_q  <= pend_nx;
      ch_q    <= ch_nx;
      req_q   <= req_nx;
      to_q    <= to_nx;
      per_q   <= per_nx;
    end
  end

  assign conv_req = req_q;
  assign conv_ch  = ch_q;
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq #(
  parameter int unsigned N_CH             = 8,
  parameter int unsigned RES_W            = 16,
  parameter int unsigned DATA_W           = 16,
  parameter int unsigned ADDR_W           = 4,
  parameter int unsigned TICK_DIV         = 100000,
  parameter int unsigned CH_TIMEOUT_TICKS = 25,
  parameter int unsigned PERIOD_TICKS     = 1000,
  parameter logic [N_CH-1:0] RANGE_CH_MASK = 8'hA0,
  localparam int unsigned CH_W = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              low_power,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              conv_req,
  output logic [CH_W-1:0]   conv_ch,
  output logic              conv_fullscale,
  input  logic              conv_done,
  input  logic [RES_W-1:0]  conv_result
);
  logic [1:0]            rst_sync_q;
  logic                  srst_n;
  logic                  tick;
  logic                  mode_bit, start_bit, range_bit;
  logic [N_CH-1:0]       mask;
  logic                  start_clr, res_we;
  logic [N_CH*RES_W-1:0] res_flat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign srst_n = rst_sync_q[1];

  scan_tick_gen #(.DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(srst_n), .tick(tick)
  );

  scan_regs #(.N_CH(N_CH), .RES_W(RES_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(srst_n), .low_power(low_power),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .start_clr(start_clr), .res_flat(res_flat),
    .mode_bit(mode_bit), .start_bit(start_bit), .range_bit(range_bit), .mask(mask)
  );

  scan_fsm #(.N_CH(N_CH), .CH_TIMEOUT_TICKS(CH_TIMEOUT_TICKS), .PERIOD_TICKS(PERIOD_TICKS)) u_fsm (
    .clk(clk), .rst_n(srst_n), .tick(tick), .low_power(low_power),
    .start_bit(start_bit), .mode_bit(mode_bit), .mask(mask), .conv_done(conv_done),
    .conv_req(conv_req), .conv_ch(conv_ch), .start_clr(start_clr), .res_we(res_we)
  );

  scan_results #(.N_CH(N_CH), .RES_W(RES_W)) u_res (
    .clk(clk), .rst_n(srst_n), .wr_en(res_we), .wr_ch(conv_ch),
    .wr_data(conv_result), .res_flat(res_flat)
  );

  assign conv_fullscale = range_bit & RANGE_CH_MASK[conv_ch];
endmodule

// File: rtl/scan_seq_checker.sv
module scan_seq_checker #(
  parameter int unsigned CH_W = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            low_power,
  input logic            conv_req,
  input logic [CH_W-1:0] conv_ch,
  input logic            conv_fullscale,
  input logic            start_bit,
  input logic            range_bit
);
  AST_REQ_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req |=> !conv_req); // R2
  AST_CH_HELD_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req |=> $stable(conv_ch)); // R3
  AST_RANGE_OTHER_CH: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_req && (conv_ch != CH_W'(5)) && (conv_ch != CH_W'(7))) |-> !conv_fullscale); // R5
  AST_RANGE_SEL_CH: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_req && ((conv_ch == CH_W'(5)) || (conv_ch == CH_W'(7)))) |-> (conv_fullscale == range_bit)); // R5
  AST_LP_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    low_power |=> !start_bit); // R9
  AST_LP_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    low_power |=> !conv_req); // R10
endmodule

bind adc_scan_seq scan_seq_checker #(.CH_W(CH_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .low_power(low_power), .conv_req(conv_req),
  .conv_ch(conv_ch), .conv_fullscale(conv_fullscale),
  .start_bit(start_bit), .range_bit(range_bit)
);

// File: tb/sim_adc_scan_seq.sv
`timescale 1ns/1ps
module sim_adc_scan_seq;
  localparam int DIV = 4, TO = 5, PER = 50;

  logic        clk, rst_n, low_power, reg_we, conv_done;
  logic [3:0]  reg_addr;
  logic [15:0] reg_wdata, reg_rdata, conv_result;
  logic        conv_req, conv_fullscale;
  logic [2:0]  conv_ch;

  int checks = 0, errors = 0, cyc = 0, nreq = 0;
  int          req_t[256];
  logic [2:0]  req_c[256];
  logic        req_f[256];
  logic [7:0]  resp_mask = 8'hFF;
  logic [15:0] res_base = 16'h0;

  adc_scan_seq #(.TICK_DIV(DIV), .CH_TIMEOUT_TICKS(TO), .PERIOD_TICKS(PER)) u0 (
    .clk(clk), .rst_n(rst_n), .low_power(low_power), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .conv_req(conv_req), .conv_ch(conv_ch), .conv_fullscale(conv_fullscale),
    .conv_done(conv_done), .conv_result(conv_result)
  );

  initial clk = 0;
  always #5 clk = ~clk;

  initial forever begin
    @(negedge clk);
    cyc++;
    if (conv_req && nreq < 256) begin
      req_t[nreq] = cyc; req_c[nreq] = conv_ch; req_f[nreq] = conv_fullscale;
      nreq++;
    end
  end

  initial begin
    conv_done = 0; conv_result = '0;
    forever begin
      @(negedge clk);
      if (conv_req && resp_mask[conv_ch]) begin
        logic [2:0] c;
        c = conv_ch;
        repeat (3) @(negedge clk);
        conv_done = 1; conv_result = res_base + 16'(c);
        @(negedge clk);
        conv_done = 0;
      end
    end
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic check_range(string req, int act, int lo, int hi);
    checks++;
    if (act < lo || act > hi) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    reg_we = 1; reg_addr = 4'(a); reg_wdata = 16'(d);
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rd(int a, output int d);
    reg_addr = 4'(a);
    #1 d = int'(reg_rdata);
  endtask

  task automatic wait_start_low(int limit);
    int v;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      rd(0, v);
      if (v[1] == 0) return;
    end
  endtask

  task automatic t_reset;
    int v;
    rd(0, v); check("R1 ctrl", v, 4);
    rd(1, v); check("R1 mask", v, 0);
    for (int c = 0; c < 8; c++) begin rd(8 + c, v); check("R1 result", v, 0); end
    check("R1 no request", nreq, 0);
  endtask

  task automatic t_oneshot;
    int v;
    nreq = 0; res_base = 16'h100; resp_mask = 8'hFF;
    wr(1, 8'hA5); wr(0, 3'b110);
    wait_start_low(2000);
    rd(0, v); check("R4 start cleared", v[1], 0);
    check("R2 request count", nreq, 4);
    check("R2 order 0", req_c[0], 0); check("R2 order 1", req_c[1], 2);
    check("R2 order 2", req_c[2], 5); check("R2 order 3", req_c[3], 7);
    check("R5 range ch0", req_f[0], 0); check("R5 range ch2", req_f[1], 0);
    check("R5 range ch5", req_f[2], 1); check("R5 range ch7", req_f[3], 1);
    rd(8, v);  check("R3 result ch0", v, 16'h100);
    rd(10, v); check("R3 result ch2", v, 16'h102);
    rd(15, v); check("R3 result ch7", v, 16'h107);
    rd(9, v);  check("R3 result ch1 untouched", v, 0);
    repeat (300) @(negedge clk);
    check("R4 single pass", nreq, 4);
  endtask

  task automatic t_range_low;
    nreq = 0;
    wr(1, 8'h20); wr(0, 3'b010);
    wait_start_low(500);
    check("R5 count", nreq, 1);
    check("R5 range low ch5", req_f[0], 0);
  endtask

  task automatic t_timeout;
    int v;
    nreq = 0; res_base = 16'h200; resp_mask = 8'hFB;
    wr(1, 8'h0E); wr(0, 3'b110);
    wait_start_low(2000);
    check("R6 count", nreq, 3);
    check("R6 next ch", req_c[2], 3);
    check_range("R6 timeout gap", req_t[2] - req_t[1], (TO - 1) * DIV + 1, TO * DIV + 4);
    rd(10, v); check("R6 result kept", v, 16'h102);
    rd(11, v); check("R6 next result", v, 16'h203);
    resp_mask = 8'hFF;
  endtask

  task automatic t_empty;
    int v;
    nreq = 0;
    wr(1, 0); wr(0, 3'b110);
    repeat (10) @(negedge clk);
    rd(0, v); check("R11 start cleared", v[1], 0);
    check("R11 no request", nreq, 0);
  endtask

  task automatic t_lp_block;
    int v;
    nreq = 0; low_power = 1;
    wr(1, 8'h03); wr(0, 3'b110);
    rd(0, v); check("R9 start blocked", v[1], 0);
    repeat (20) @(negedge clk);
    low_power = 0;
    repeat (50) @(negedge clk);
    rd(0, v); check("R9 start still low", v[1], 0);
    check("R9 no request", nreq, 0);
  endtask

  task automatic t_lp_abort;
    int v, n;
    nreq = 0; resp_mask = 8'h00;
    wr(1, 8'hFF); wr(0, 3'b110);
    for (int i = 0; i < 2000 && nreq < 2; i++) @(negedge clk);
    low_power = 1;
    repeat (2) @(negedge clk);
    n = nreq;
    repeat (150) @(negedge clk);
    check("R10 no more requests", nreq, n);
    check("R10 aborted early", n < 8, 1);
    rd(0, v); check("R10 start cleared", v[1], 0);
    low_power = 0;
    repeat (100) @(negedge clk);
    check("R10 stays idle", nreq, n);
    resp_mask = 8'hFF;
  endtask

  task automatic t_continuous;
    int v;
    nreq = 0; res_base = 16'h300;
    wr(1, 8'h03); wr(0, 3'b111);
    for (int i = 0; i < 2000 && nreq < 7; i++) @(negedge clk);
    wr(0, 3'b110);
    check_range("R7 period 1", req_t[2] - req_t[0], (PER - 1) * DIV, PER * DIV + 5);
    check_range("R7 period 2", req_t[4] - req_t[2], (PER - 1) * DIV, PER * DIV + 5);
    check("R7 order", req_c[4], 0);
    wait_start_low(2000);
    check("R8 pass finished", nreq, 8);
    check("R8 last ch", req_c[7], 1);
    rd(9, v); check("R8 last result", v, 16'h301);
    repeat (400) @(negedge clk);
    check("R8 stopped", nreq, 8);
  endtask

  task automatic t_cont_start_held;
    int v;
    nreq = 0;
    wr(1, 8'h01); wr(0, 3'b111);
    repeat (60) @(negedge clk);
    rd(0, v); check("R7 start held", v[1], 1);
    wr(0, 3'b100);
    wait_start_low(500);
    repeat (300) @(negedge clk);
    check("R7 one pass before stop", nreq, 1);
  endtask

  initial begin
    repeat (150000) @(negedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 0; low_power = 0; reg_we = 0; reg_addr = '0; reg_wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    t_reset;
    t_oneshot;
    t_range_low;
    t_timeout;
    t_empty;
    t_lp_block;
    t_lp_abort;
    t_continuous;
    t_cont_start_held;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule